// File: doc/BRIEF.md
# Raster Output Enable and Underrun Recovery Controller

This block sequences the enable and disable of a raster display engine and keeps its interrupt status. It does not make pixels or count timing. It sees frame-start and frame-end strobes from the timing generator, a pixel-request strobe with a first-pixel-of-line flag, and the empty flag of the pixel FIFO. From these it decides when output is live and which events to report.

Setting the enable starts a palette fetch, unless the palette mode is data-only. The block then waits for the start of a new frame before it turns the output on. Clearing the enable does not cut the picture. The frame in progress is finished, and a frame-done status marks the moment the engine is quiet.

A starved FIFO is reported as an underflow. When the starvation hits the first pixel of a line, it is also reported as a loss of sync. The output is then dropped and re-armed for the next frame. Status bits are write-one-to-clear. The interrupt line gives one pulse and stays silent until software writes the end-of-interrupt strobe. A main reset input holds the core idle and clears its status.

Top module: `raster_ctl`

## Requirements
- R1: After rst_n is released, raster_on_o, pal_fetch_o, irq_o and all of status_o are 0.
- R2: Setting raster_en_i with pal_data_only_i = 0 raises pal_fetch_o one cycle later. It stays high until a cycle with pal_ack_i high. In the cycle after the acknowledge, status_o[3] (palette done) is set and pal_fetch_o is low. With pal_data_only_i = 1, pal_fetch_o never rises and status_o[3] is not set.
- R3: Output starts only on a fresh frame. Once the block is armed, raster_on_o rises in the cycle after a frame_start_i pulse and never at any other time.
- R4: Clearing raster_en_i while output is live keeps raster_on_o high until frame_end_i. In the cycle after frame_end_i, raster_on_o is 0 and status_o[0] (frame done) is set.
- R5: While output is live, a cycle with pix_req_i and fifo_empty_i sets status_o[2] (underflow) in the next cycle. If line_first_i is also high, status_o[1] (sync lost) is set in that same cycle.
- R6: After a sync-lost event with the enable still set, raster_on_o is 0 in the next cycle and rises again only after the next frame_start_i. If the event happens while a disable is draining, the frame ends and status_o[0] is set.
- R7: A bit of sts_clr_i clears the matching status bit in the next cycle. An event that sets the same bit in the same cycle wins over the clear.
- R8: irq_o is a one-cycle pulse. It is issued in the cycle after one in which the line is armed and status_o & irq_mask_i is non-zero. The line is then disarmed. An eoi_i pulse re-arms it, and a pending masked status then produces the next pulse one cycle later.
- R9: While main_rst_i is high, the next cycle shows raster_on_o, pal_fetch_o, irq_o and status_o all at 0. The enable and frame strobes are ignored, and the interrupt line is armed.
- R10: While output is not live, pix_req_i, line_first_i and fifo_empty_i have no effect on status_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_rst_i | input | 1 | Software main reset of the core, active high |
| raster_en_i | input | 1 | Raster enable level |
| pal_data_only_i | input | 1 | 1: skip the palette fetch |
| pal_ack_i | input | 1 | Palette fetch finished |
| frame_start_i | input | 1 | Start-of-frame strobe |
| frame_end_i | input | 1 | End-of-frame strobe |
| pix_req_i | input | 1 | Active pixel wanted this cycle |
| line_first_i | input | 1 | The requested pixel is the first of its line |
| fifo_empty_i | input | 1 | Pixel FIFO empty |
| sts_clr_i | input | 4 | Write-one-to-clear strobes for status |
| irq_mask_i | input | 4 | Interrupt enable per status bit |
| eoi_i | input | 1 | End-of-interrupt strobe, re-arms the line |
| pal_fetch_o | output | 1 | Palette fetch request |
| raster_on_o | output | 1 | Raster output live |
| status_o | output | 4 | Status: [0] frame done, [1] sync lost, [2] underflow, [3] palette done |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The properties assume that frame_start_i and frame_end_i are single-cycle strobes, and that pal_ack_i is raised only while pal_fetch_o is high. They also assume that eoi_i is not written in the same cycle that the line fires, because the re-arm would then be lost. The stimulus follows these rules in three ways. A frame generator produces the strobes. The acknowledge is driven from the observed fetch request. The end-of-interrupt strobe is held back whenever the bench's own model predicts a pulse on the next edge. Within those limits, the underrun, line-start and clear strobes are random and may hit any state, including the drain phase and the main reset.

// File: rtl/raster_ctl_pkg.sv
package raster_ctl_pkg;

  localparam int unsigned STS_W  = 4;
  localparam int unsigned STS_FD = 0;
  localparam int unsigned STS_SL = 1;
  localparam int unsigned STS_UF = 2;
  localparam int unsigned STS_PD = 3;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_PAL   = 3'd1,
    SEQ_ARM   = 3'd2,
    SEQ_SCAN  = 3'd3,
    SEQ_DRAIN = 3'd4
  } seq_state_e;

  // set wins over a clear of the same bit
  function automatic logic [STS_W-1:0] sts_update(
    input logic [STS_W-1:0] cur,
    input logic [STS_W-1:0] set,
    input logic [STS_W-1:0] clr
  );
    return (cur & ~clr) | set;
  endfunction

  function automatic logic irq_pending(
    input logic [STS_W-1:0] sts,
    input logic [STS_W-1:0] mask
  );
    return |(sts & mask);
  endfunction

  function automatic logic is_live(input seq_state_e st);
    return (st == SEQ_SCAN) || (st == SEQ_DRAIN);
  endfunction

endpackage

// File: rtl/raster_ctl_evt.sv
module raster_ctl_evt (
  input  logic live_i,
  input  logic pix_req_i,
  input  logic line_first_i,
  input  logic fifo_empty_i,
  output logic uf_evt_o,
  output logic sl_evt_o
);
  // starvation only counts while output is live
  always_comb begin
    uf_evt_o = live_i & pix_req_i & fifo_empty_i;
    sl_evt_o = uf_evt_o & line_first_i;
  end
endmodule

// File: rtl/raster_ctl_seq.sv
module raster_ctl_seq
  import raster_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic main_rst_i,
  input  logic en_i,
  input  logic pal_data_only_i,
  input  logic pal_ack_i,
  input  logic frame_start_i,
  input  logic frame_end_i,
  input  logic sl_evt_i,
  output logic pal_fetch_o,
  output logic live_o,
  output logic pd_evt_o,
  output logic fd_evt_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    pd_evt_o = 1'b0;
    fd_evt_o = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (en_i) st_d = pal_data_only_i ? SEQ_ARM : SEQ_PAL;
      end
      SEQ_PAL: begin
        if (pal_ack_i) begin
          pd_evt_o = 1'b1;
          st_d     = SEQ_ARM;
        end
      end
      SEQ_ARM: begin
        if (!en_i)              st_d = SEQ_IDLE;
        else if (frame_start_i) st_d = SEQ_SCAN;
      end
      SEQ_SCAN: begin
        if (sl_evt_i) begin
          if (en_i) st_d = SEQ_ARM;
          else begin
            st_d     = SEQ_IDLE;
            fd_evt_o = 1'b1;
          end
        end else if (!en_i && frame_end_i) begin
          st_d     = SEQ_IDLE;
          fd_evt_o = 1'b1;
        end else if (!en_i) begin
          st_d = SEQ_DRAIN;
        end
      end
      SEQ_DRAIN: begin
        if (frame_end_i || sl_evt_i) begin
          st_d     = SEQ_IDLE;
          fd_evt_o = 1'b1;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
    if (main_rst_i) begin
      st_d     = SEQ_IDLE;
      pd_evt_o = 1'b0;
      fd_evt_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    live_o      = is_live(st_q);
    pal_fetch_o = (st_q == SEQ_PAL);
  end
endmodule

// File: rtl/raster_ctl_irq.sv
module raster_ctl_irq
  import raster_ctl_pkg::*;
#(
  parameter int unsigned W = STS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         main_rst_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  input  logic         eoi_i,
  output logic [W-1:0] sts_o,
  output logic         irq_o
);
  logic [W-1:0] sts_q;
  logic         armed_q;
  logic         irq_q;
  logic         fire;

  always_comb fire = armed_q & irq_pending(sts_q, mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (main_rst_i) begin
      sts_q   <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      sts_q   <= sts_update(sts_q, set_i, clr_i);
      irq_q   <= fire;
      if (fire)       armed_q <= 1'b0;
      else if (eoi_i) armed_q <= 1'b1;
    end
  end

  always_comb begin
    sts_o = sts_q;
    irq_o = irq_q;
  end
endmodule

// File: rtl/raster_ctl.sv
module raster_ctl
  import raster_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_rst_i,
  input  logic             raster_en_i,
  input  logic             pal_data_only_i,
  input  logic             pal_ack_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic             pix_req_i,
  input  logic             line_first_i,
  input  logic             fifo_empty_i,
  input  logic [STS_W-1:0] sts_clr_i,
  input  logic [STS_W-1:0] irq_mask_i,
  input  logic             eoi_i,
  output logic             pal_fetch_o,
  output logic             raster_on_o,
  output logic [STS_W-1:0] status_o,
  output logic             irq_o
);
  logic             live;
  logic             uf_evt;
  logic             sl_evt;
  logic             pd_evt;
  logic             fd_evt;
  logic [STS_W-1:0] set_vec;

  raster_ctl_evt u_evt (
    .live_i       (live),
    .pix_req_i    (pix_req_i),
    .line_first_i (line_first_i),
    .fifo_empty_i (fifo_empty_i),
    .uf_evt_o     (uf_evt),
    .sl_evt_o     (sl_evt)
  );

  raster_ctl_seq u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .main_rst_i      (main_rst_i),
    .en_i            (raster_en_i),
    .pal_data_only_i (pal_data_only_i),
    .pal_ack_i       (pal_ack_i),
    .frame_start_i   (frame_start_i),
    .frame_end_i     (frame_end_i),
    .sl_evt_i        (sl_evt),
    .pal_fetch_o     (pal_fetch_o),
    .live_o          (live),
    .pd_evt_o        (pd_evt),
    .fd_evt_o        (fd_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[STS_FD] = fd_evt;
    set_vec[STS_SL] = sl_evt;
    set_vec[STS_UF] = uf_evt;
    set_vec[STS_PD] = pd_evt;
  end

  raster_ctl_irq #(.W(STS_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_rst_i (main_rst_i),
    .set_i      (set_vec),
    .clr_i      (sts_clr_i),
    .mask_i     (irq_mask_i),
    .eoi_i      (eoi_i),
    .sts_o      (status_o),
    .irq_o      (irq_o)
  );

  always_comb raster_on_o = live;
endmodule

// File: rtl/raster_ctl_chk.sv
module raster_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       main_rst_i,
  input logic       raster_en_i,
  input logic       frame_start_i,
  input logic       frame_end_i,
  input logic       pal_fetch_o,
  input logic       pal_ack_i,
  input logic       fifo_empty_i,
  input logic       pix_req_i,
  input logic       raster_on_o,
  input logic [3:0] status_o,
  input logic       irq_o,
  input logic       sl_evt
);
  assert_pal_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[3]) |-> $past(pal_fetch_o && pal_ack_i));

  assert_fresh_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raster_on_o) |-> $past(frame_start_i));

  assert_drain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raster_on_o && !raster_en_i && !frame_end_i && !sl_evt && !main_rst_i |=> raster_on_o);

  assert_drain_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raster_on_o && !raster_en_i && frame_end_i && !main_rst_i |=> !raster_on_o && status_o[0]);

  assert_sync_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sl_evt && !main_rst_i |=> !raster_on_o && status_o[1] && status_o[2]);

  assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_main_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    main_rst_i |=> status_o == 4'd0 && !raster_on_o && !irq_o && !pal_fetch_o);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[2]) |-> $past(raster_on_o && fifo_empty_i && pix_req_i));
endmodule

bind raster_ctl raster_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .main_rst_i    (main_rst_i),
  .raster_en_i   (raster_en_i),
  .frame_start_i (frame_start_i),
  .frame_end_i   (frame_end_i),
  .pal_fetch_o   (pal_fetch_o),
  .pal_ack_i     (pal_ack_i),
  .fifo_empty_i  (fifo_empty_i),
  .pix_req_i     (pix_req_i),
  .raster_on_o   (raster_on_o),
  .status_o      (status_o),
  .irq_o         (irq_o),
  .sl_evt        (sl_evt)
);

// File: tb/sim_raster_ctl.sv
`timescale 1ns/1ps
module sim_raster_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_rst_i = 1'b0, raster_en_i = 1'b0, pal_data_only_i = 1'b0;
  logic       pal_ack_i = 1'b0, frame_start_i = 1'b0, frame_end_i = 1'b0;
  logic       pix_req_i = 1'b0, line_first_i = 1'b0, fifo_empty_i = 1'b0;
  logic [3:0] sts_clr_i = 4'd0, irq_mask_i = 4'hF;
  logic       eoi_i = 1'b0;
  logic       pal_fetch_o, raster_on_o, irq_o;
  logic [3:0] status_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #5 clk = ~clk;

  raster_ctl u0 (.*);

  // reference model: 0 idle, 1 palette, 2 armed, 3 scan, 4 drain
  int         m_st, ns;
  logic [3:0] m_sts, setv;
  logic       m_armed, m_irq, on, uf, sl, fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sts = 4'd0; m_armed = 1'b1; m_irq = 1'b0;
    end else begin
      on = (m_st == 3) || (m_st == 4);
      uf = on && fifo_empty_i && pix_req_i;
      sl = uf && line_first_i;
      setv = {1'b0, uf, sl, 1'b0};
      ns = m_st;
      case (m_st)
        0: if (raster_en_i) ns = pal_data_only_i ? 2 : 1;
        1: if (pal_ack_i) begin setv[3] = 1'b1; ns = 2; end
        2: if (!raster_en_i) ns = 0; else if (frame_start_i) ns = 3;
        3: if (sl) begin
             if (raster_en_i) ns = 2; else begin ns = 0; setv[0] = 1'b1; end
           end else if (!raster_en_i && frame_end_i) begin ns = 0; setv[0] = 1'b1; end
           else if (!raster_en_i) ns = 4;
        4: if (frame_end_i || sl) begin ns = 0; setv[0] = 1'b1; end
        default: ns = 0;
      endcase
      fire = m_armed && |(m_sts & irq_mask_i);
      if (main_rst_i) begin
        ns = 0; m_sts = 4'd0; m_armed = 1'b1; m_irq = 1'b0;
      end else begin
        m_irq = fire;
        if (fire) m_armed = 1'b0; else if (eoi_i) m_armed = 1'b1;
        m_sts = (m_sts & ~sts_clr_i) | setv;
      end
      m_st = ns;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && rst_n && !done) begin
      chk("R3 raster_on", {7'd0, raster_on_o}, {7'd0, (m_st == 3) || (m_st == 4)});
      chk("R2 pal_fetch", {7'd0, pal_fetch_o}, {7'd0, m_st == 1});
      chk("R7 status",    {4'd0, status_o},    {4'd0, m_sts});
      chk("R8 irq",       {7'd0, irq_o},       {7'd0, m_irq});
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int period, cnt;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    step();
    chk("R1 reset on",     {7'd0, raster_on_o}, 8'd0);
    chk("R1 reset status", {4'd0, status_o},    8'd0);
    chk("R1 reset irq",    {7'd0, irq_o},       8'd0);
    chk("R1 reset fetch",  {7'd0, pal_fetch_o}, 8'd0);

    // palette load path
    raster_en_i = 1'b1; step();
    chk("R2 fetch raised", {7'd0, pal_fetch_o}, 8'd1);
    step();
    chk("R2 fetch held", {7'd0, pal_fetch_o}, 8'd1);
    pal_ack_i = 1'b1; step(); pal_ack_i = 1'b0;
    chk("R2 pal done", {7'd0, status_o[3]}, 8'd1);
    chk("R2 fetch low", {7'd0, pal_fetch_o}, 8'd0);
    step();
    chk("R8 irq pulse", {7'd0, irq_o}, 8'd1);
    step();
    chk("R8 irq one cycle", {7'd0, irq_o}, 8'd0);
    sts_clr_i = 4'h8; step(); sts_clr_i = 4'h0;
    chk("R7 clear", {4'd0, status_o}, 8'd0);
    step();
    chk("R3 armed waits", {7'd0, raster_on_o}, 8'd0);
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    chk("R3 starts", {7'd0, raster_on_o}, 8'd1);

    // underflow without line start
    pix_req_i = 1'b1; fifo_empty_i = 1'b1; step();
    pix_req_i = 1'b0; fifo_empty_i = 1'b0;
    chk("R5 underflow", {4'd0, status_o}, 8'h4);
    chk("R5 still on", {7'd0, raster_on_o}, 8'd1);
    sts_clr_i = 4'h4; step(); sts_clr_i = 4'h0;

    // deferred disable
    raster_en_i = 1'b0; step();
    chk("R4 drain on", {7'd0, raster_on_o}, 8'd1);
    repeat (3) step();
    chk("R4 drain hold", {7'd0, raster_on_o}, 8'd1);
    frame_end_i = 1'b1; step(); frame_end_i = 1'b0;
    chk("R4 off", {7'd0, raster_on_o}, 8'd0);
    chk("R4 frame done", {7'd0, status_o[0]}, 8'd1);

    // events while off
    pix_req_i = 1'b1; fifo_empty_i = 1'b1; line_first_i = 1'b1; step();
    pix_req_i = 1'b0; fifo_empty_i = 1'b0; line_first_i = 1'b0;
    chk("R10 ignored", {6'd0, status_o[2:1]}, 8'd0);

    // data-only enable and sync loss
    pal_data_only_i = 1'b1; raster_en_i = 1'b1; step();
    chk("R2 no fetch", {7'd0, pal_fetch_o}, 8'd0);
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    chk("R3 on again", {7'd0, raster_on_o}, 8'd1);
    pix_req_i = 1'b1; fifo_empty_i = 1'b1; line_first_i = 1'b1; step();
    pix_req_i = 1'b0; fifo_empty_i = 1'b0; line_first_i = 1'b0;
    chk("R6 dropped", {7'd0, raster_on_o}, 8'd0);
    chk("R5 both bits", {6'd0, status_o[2:1]}, 8'd3);
    step();
    chk("R6 waits frame", {7'd0, raster_on_o}, 8'd0);
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    chk("R6 resumes", {7'd0, raster_on_o}, 8'd1);

    // set wins over clear
    sts_clr_i = 4'hF; step(); sts_clr_i = 4'h0;
    chk("R7 all clear", {4'd0, status_o}, 8'd0);
    raster_en_i = 1'b0; step();
    frame_end_i = 1'b1; sts_clr_i = 4'h1; step();
    frame_end_i = 1'b0; sts_clr_i = 4'h0;
    chk("R7 set wins", {7'd0, status_o[0]}, 8'd1);
    step();
    chk("R8 disarmed", {7'd0, irq_o}, 8'd0);
    eoi_i = 1'b1; step(); eoi_i = 1'b0;
    chk("R8 rearm edge", {7'd0, irq_o}, 8'd0);
    step();
    chk("R8 after eoi", {7'd0, irq_o}, 8'd1);

    // main reset
    raster_en_i = 1'b1; step();
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    main_rst_i = 1'b1; step();
    chk("R9 off", {7'd0, raster_on_o}, 8'd0);
    chk("R9 status", {4'd0, status_o}, 8'd0);
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    chk("R9 enable ignored", {7'd0, raster_on_o}, 8'd0);
    chk("R9 no fetch", {7'd0, pal_fetch_o}, 8'd0);
    main_rst_i = 1'b0; step();
    frame_start_i = 1'b1; step(); frame_start_i = 1'b0;
    chk("R9 recovers", {7'd0, raster_on_o}, 8'd1);

    // constrained random phase
    period = 20; cnt = 0;
    for (int i = 0; i < 6000; i++) begin
      frame_start_i = (cnt == 0);
      frame_end_i   = (cnt == period - 3);
      cnt++;
      if (cnt >= period) begin cnt = 0; period = 12 + int'($urandom_range(18)); end
      if ($urandom_range(39) == 0) raster_en_i = ~raster_en_i;
      if ($urandom_range(49) == 0) pal_data_only_i = ~pal_data_only_i;
      main_rst_i   = ($urandom_range(299) == 0);
      pix_req_i    = $urandom_range(1) == 1;
      line_first_i = pix_req_i && ($urandom_range(7) == 0);
      fifo_empty_i = ($urandom_range(19) == 0);
      pal_ack_i    = pal_fetch_o && ($urandom_range(3) == 0);
      sts_clr_i    = ($urandom_range(5) == 0) ? 4'($urandom_range(15)) : 4'd0;
      if ($urandom_range(99) == 0) irq_mask_i = 4'($urandom_range(15));
      eoi_i = ($urandom_range(9) == 0) && !(m_armed && |(m_sts & irq_mask_i));
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule